// File: doc/BRIEF.md
# Turn-Synchronous Pattern Player

The block plays a stored timing pattern onto a set of channel outputs, one memory word per accelerator-clock tick. A pattern memory of twice `2**HALF_AW` words is split into a lower and an upper half. A control register bit chooses which half is played. An offset counter, `HALF_AW` bits wide, walks that half. Because it is only `HALF_AW` bits wide, playback can never spill from one half into the other. Each word read appears on the channel outputs one clock after the counter addresses it.

The counter restarts from a programmable preset offset for two reasons, and each reason has its own enable. The first is the once-per-turn crossing marker, which acts as a parallel load on the tick. The second is a match against a programmable terminal offset. That offset is usually placed a few words beyond the point where the crossing marker normally restarts the pattern, so it only acts as a safety stop. Both offsets are given relative to the selected half. Absolute address 1100, for example, is programmed as offset 76.

Preset, terminal offset and control are written one byte at a time through a function-code register port. The pattern memory is filled through a separate plain write port.

Top module: `turn_pattern_player`

## Requirements
- R1: After reset, the play offset is 0, the channel outputs are 0 and the control readback is 0.
- R2: The counter advances by one on a cycle where the tick input is high and control bit 4 (clock enable) is set. In any other cycle it holds.
- R3: One clock after the counter holds offset A, the channel outputs show the memory word at absolute address {half bit, A}.
- R4: Control bit 3 selects the half. When it is set, playback reads memory addresses 1024 + offset.
- R5: Function code 33 writes the preset low byte and 34 writes the preset high byte. The preset offset is (high × 256 + low) modulo 1024.
- R6: Function code 35 writes the terminal low byte and 36 writes the terminal high byte. The terminal offset is (high × 256 + low) modulo 1024.
- R7: Function code 37 writes the control register, and all 8 bits read back as written. A write with any other function code leaves the control readback unchanged.
- R8: On an advancing cycle where the crossing input is high and control bit 1 is set, the counter loads the preset. When bit 1 is clear, the crossing input has no effect.
- R9: On an advancing cycle where the offset equals the terminal offset and control bit 2 is set, the counter loads the preset. When bit 2 is clear, the counter steps past the terminal offset.
- R10: When the crossing load and the terminal load fire together, the counter loads the preset.
- R11: With no load, an advance from offset 1023 gives offset 0 in the same half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_tick | input | 1 | Accelerator tick, advances the counter |
| xing_mark | input | 1 | Once-per-turn crossing marker, sampled on the tick |
| reg_we | input | 1 | Register write strobe |
| reg_fn | input | 8 | Function code of the register write |
| reg_wdata | input | 8 | Byte written to the register |
| mem_we | input | 1 | Pattern memory write strobe |
| mem_waddr | input | HALF_AW+1 | Absolute pattern memory address |
| mem_wdata | input | CH_W | Pattern word |
| chan_out | output | CH_W | Channel outputs, registered |
| play_off | output | HALF_AW | Current play offset |
| ctrl_rd | output | 8 | Control register readback |

## Verification
The bench builds the block with its defaults: CH_W = 8 and HALF_AW = 10. This brings the full 2048-word memory, the 1023-to-0 wrap and the high-byte truncation of the preset within reach. The whole memory is filled with an address-derived pattern, so each channel word identifies both its half and its offset. A short walk of about 260 ticks reaches a terminal offset that depends on the high byte.

// File: rtl/turn_pattern_player.sv
module turn_pattern_player #(
  parameter int CH_W        = 8,
  parameter int HALF_AW     = 10,
  parameter logic [7:0] FN_PRE_LO = 8'd33,
  parameter logic [7:0] FN_PRE_HI = 8'd34,
  parameter logic [7:0] FN_TC_LO  = 8'd35,
  parameter logic [7:0] FN_TC_HI  = 8'd36,
  parameter logic [7:0] FN_CTRL   = 8'd37
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_tick,
  input  logic               xing_mark,
  input  logic               reg_we,
  input  logic [7:0]         reg_fn,
  input  logic [7:0]         reg_wdata,
  input  logic               mem_we,
  input  logic [HALF_AW:0]   mem_waddr,
  input  logic [CH_W-1:0]    mem_wdata,
  output logic [CH_W-1:0]    chan_out,
  output logic [HALF_AW-1:0] play_off,
  output logic [7:0]         ctrl_rd
);
  localparam int DEPTH  = 2 ** (HALF_AW + 1);
  localparam int HI_W   = HALF_AW - 8;
  localparam int B_XING = 1;
  localparam int B_TC   = 2;
  localparam int B_HALF = 3;
  localparam int B_CLK  = 4;

  logic [CH_W-1:0]    mem [DEPTH];
  logic [HALF_AW-1:0] cnt_q, preset_q, tc_q;
  logic [7:0]         ctrl_q;

  wire adv     = acc_tick & ctrl_q[B_CLK];
  wire xing_ld = xing_mark & ctrl_q[B_XING];
  wire tc_ld   = ctrl_q[B_TC] & (cnt_q == tc_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preset_q <= '0;
      tc_q     <= '0;
      ctrl_q   <= '0;
    end else if (reg_we) begin
      case (reg_fn)
        FN_PRE_LO: preset_q[7:0]         <= reg_wdata;
        FN_PRE_HI: preset_q[HALF_AW-1:8] <= reg_wdata[HI_W-1:0];
        FN_TC_LO:  tc_q[7:0]             <= reg_wdata;
        FN_TC_HI:  tc_q[HALF_AW-1:8]     <= reg_wdata[HI_W-1:0];
        FN_CTRL:   ctrl_q                <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (adv && (xing_ld || tc_ld)) cnt_q <= preset_q;
    else if (adv)                 cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) chan_out <= '0;
    else        chan_out <= mem[{ctrl_q[B_HALF], cnt_q}];
  end

  assign play_off = cnt_q;
  assign ctrl_rd  = ctrl_q;
endmodule

module turn_pattern_player_chk #(
  parameter int HALF_AW = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_tick,
  input logic               xing_mark,
  input logic [7:0]         ctrl_q,
  input logic [HALF_AW-1:0] cnt_q,
  input logic [HALF_AW-1:0] preset_q,
  input logic [HALF_AW-1:0] tc_q
);
  wire go  = acc_tick && ctrl_q[4];
  wire xl  = xing_mark && ctrl_q[1];
  wire tl  = ctrl_q[2] && (cnt_q == tc_q);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(cnt_q));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !xl && !tl) |=> cnt_q == HALF_AW'($past(cnt_q) + 1'b1));

  assert_xing_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && xl) |=> cnt_q == $past(preset_q));

  assert_tc_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && tl) |=> cnt_q == $past(preset_q));

  assert_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !xl && !tl && (&cnt_q)) |=> cnt_q == '0);
endmodule

bind turn_pattern_player turn_pattern_player_chk #(.HALF_AW(HALF_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_tick(acc_tick), .xing_mark(xing_mark),
  .ctrl_q(ctrl_q), .cnt_q(cnt_q), .preset_q(preset_q), .tc_q(tc_q)
);

// File: tb/sim_turn_pattern_player.sv
module sim_turn_pattern_player;
  logic        clk = 0, rst_n = 0, acc_tick = 0, xing_mark = 0;
  logic        reg_we = 0, mem_we = 0;
  logic [7:0]  reg_fn = 0, reg_wdata = 0, mem_wdata = 0;
  logic [10:0] mem_waddr = 0;
  logic [7:0]  chan_out, ctrl_rd;
  logic [9:0]  play_off;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  turn_pattern_player u0 (.*);

  // bit 11 tick, bit 10 crossing, bits 9:0 expected offset (ctrl 22, preset 100, terminal 105)
  localparam logic [11:0] VEC [0:12] = '{
    {2'b10, 10'd1},   {2'b10, 10'd2},   {2'b00, 10'd2},   {2'b11, 10'd100},
    {2'b10, 10'd101}, {2'b10, 10'd102}, {2'b01, 10'd102}, {2'b10, 10'd103},
    {2'b10, 10'd104}, {2'b10, 10'd105}, {2'b10, 10'd100}, {2'b10, 10'd101},
    {2'b11, 10'd100}
  };

  function automatic logic [7:0] pat(int a);
    return 8'(a * 5 + (a >> 8) * 29 + (a >> 10) * 77 + 3);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(logic t, logic x);
    acc_tick = t; xing_mark = x;
    @(posedge clk); #5;
    acc_tick = 0; xing_mark = 0;
  endtask

  task automatic wreg(logic [7:0] fn, logic [7:0] d);
    reg_we = 1; reg_fn = fn; reg_wdata = d;
    cyc(0, 0);
    reg_we = 0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int prev;
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    chk("R1 offset", play_off, 0);
    chk("R1 chan", chan_out, 0);
    chk("R1 ctrl", ctrl_rd, 0);

    for (int a = 0; a < 2048; a++) begin
      mem_we = 1; mem_waddr = 11'(a); mem_wdata = pat(a);
      cyc(0, 0);
    end
    mem_we = 0;

    wreg(33, 100); wreg(34, 0); wreg(35, 105); wreg(36, 0); wreg(37, 22);
    chk("R7 ctrl", ctrl_rd, 22);
    prev = 0;
    for (int i = 0; i < 13; i++) begin
      cyc(VEC[i][11], VEC[i][10]);
      chk("R2/R8/R9 offset", play_off, VEC[i][9:0]);
      chk("R3 chan", chan_out, pat(prev));
      prev = VEC[i][9:0];
    end

    repeat (5) cyc(1, 0);
    chk("R9 reach terminal", play_off, 105);
    cyc(1, 1);
    chk("R10 both loads", play_off, 100);

    wreg(37, 18);
    repeat (6) cyc(1, 0);
    chk("R9 terminal ignored", play_off, 106);
    wreg(37, 20);
    cyc(1, 1);
    chk("R8 crossing ignored", play_off, 107);
    wreg(37, 6);
    cyc(1, 0);
    chk("R2 clock disabled", play_off, 107);
    wreg(38, 0);
    chk("R7 other code", ctrl_rd, 6);

    wreg(33, 252); wreg(34, 7); wreg(37, 18);
    cyc(1, 1);
    chk("R5 preset high byte", play_off, 1020);
    wreg(37, 16);
    repeat (3) cyc(1, 0);
    chk("R11 top", play_off, 1023);
    cyc(1, 0);
    chk("R11 wrap", play_off, 0);

    wreg(37, 24);
    cyc(1, 0);
    cyc(1, 0);
    chk("R4 upper half", chan_out, pat(1025));

    wreg(35, 2); wreg(36, 1); wreg(37, 28);
    repeat (256) cyc(1, 0);
    chk("R6 terminal reached", play_off, 258);
    cyc(1, 0);
    chk("R6 terminal load", play_off, 1020);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule